// File: doc/BRIEF.md
# Sticky-Collecting Mantissa Right Shifter

This block aligns a wide floating-point mantissa by shifting it toward the least significant end. Every bit that leaves the bottom of the mantissa is folded into a single sticky flag, so a later rounding stage still knows that something non-zero was discarded. The mantissa arrives as three 32-bit words, with word 0 the most significant. A sticky bit that an earlier step already produced comes in beside it and is carried forward.

The shift runs in two steps. A control decoder first turns the 7-bit amount into a one-hot whole-word move selection, a sub-word bit count and a saturation strobe. A datapath then moves whole words, shifts the remaining bits across word boundaries and reduces the lost bits into the sticky flag.

Amounts at or above a saturation limit (parameter, default 67) collapse the mantissa to zero and force the sticky flag high. An optional output register (parameter, on by default) gives the block one cycle of latency.

Top module: `mant_rshift_sticky`

## Requirements
- R1: Word 0 is the most significant word and word 2 the least. A shift by one moves bit 0 of word 0 into bit 31 of word 1, and bit 0 of word 1 into bit 31 of word 2.
- R2: When the amount is at or above SAT_LIMIT (default 67), all three output words are zero and the sticky output is 1. This holds even for a zero mantissa with sticky input 0.
- R3: For an amount from 64 up to SAT_LIMIT-1, output words 0 and 1 are zero, and output word 2 equals input word 0 shifted right by (amount-64).
- R4: For an amount from 32 to 63, output word 0 is zero. Output word 1 is input word 0 shifted right by (amount-32), and input word 2 is discarded into sticky.
- R5: For an amount from 1 to 31, the 96-bit concatenation {w0,w1,w2} is shifted right as one value. Each word receives the low bits of the word above it at its top.
- R6: Below SAT_LIMIT, the sticky output is the OR of every input bit shifted out of the bottom, ORed with the sticky input. It is 0 when no set bit is lost and the sticky input is 0.
- R7: A sticky input of 1 always yields a sticky output of 1.
- R8: An amount of 0 passes the mantissa and the sticky input through unchanged.
- R9: With the output register enabled, reset clears all output words and the sticky output to 0. A result appears on the outputs after the first rising clock edge that follows the input, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| mantW0 | input | 32 | Mantissa word 0 (most significant) |
| mantW1 | input | 32 | Mantissa word 1 |
| mantW2 | input | 32 | Mantissa word 2 (least significant) |
| stickyIn | input | 1 | Sticky flag from earlier processing |
| shiftAmt | input | 7 | Unsigned right-shift amount in bits |
| mantW0Out | output | 32 | Shifted word 0 |
| mantW1Out | output | 32 | Shifted word 1 |
| mantW2Out | output | 32 | Shifted word 2 |
| stickyOut | output | 1 | Accumulated sticky flag |

## Verification
The bench targets the amounts that sit on a decoding edge: 0, 31, 32, 33, 63, 64, 66, 67 and 127. A wrong word-move boundary shows up there as a word left in place or moved one slot too far. A single set bit placed exactly at the cut point of a shift checks the sticky reduction: a design that forgets to fold in dropped words, or leaks a kept bit into sticky, reports the wrong flag. A zero mantissa with a saturating amount checks that saturation forces sticky high instead of deriving it from the data. Random vectors with occasional all-zero words catch errors in carrying bits across word boundaries.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  // word geometry of the mantissa
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 3;
  localparam int MANT_W    = WORD_W * NUM_WORDS;
  localparam int AMT_W     = 7;
  localparam int BSEL_W    = $clog2(WORD_W);

  // strobes from the amount decoder to the datapath
  typedef struct packed {
    logic                 saturate;  // everything shifts out
    logic [NUM_WORDS-1:0] moveSel;   // one-hot whole-word move count
    logic [BSEL_W-1:0]    bitSel;    // residual sub-word shift
  } shift_ctrl_t;

endpackage

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
  import mrs_pkg::*;
#(
  parameter int SAT_LIMIT = 67
) (
  input  logic [AMT_W-1:0] shiftAmt,
  output shift_ctrl_t      ctrl
);

  localparam int WIDX_W = AMT_W - BSEL_W;

  logic [WIDX_W-1:0] wordIdx;
  logic              satNow;

  assign wordIdx = shiftAmt[AMT_W-1:BSEL_W];
  assign satNow  = (int'(shiftAmt) >= SAT_LIMIT);

  always_comb begin
    ctrl          = '0;
    ctrl.saturate = satNow;
    ctrl.bitSel   = shiftAmt[BSEL_W-1:0];
    for (int k = 0; k < NUM_WORDS; k++) begin
      ctrl.moveSel[k] = !satNow && (int'(wordIdx) == k);
    end
  end

endmodule

// File: rtl/mrs_datapath.sv
module mrs_datapath
  import mrs_pkg::*;
(
  input  logic [MANT_W-1:0] mantIn,
  input  logic              stickyIn,
  input  shift_ctrl_t       ctrl,
  output logic [MANT_W-1:0] mantOut,
  output logic              stickyOut
);

  logic [MANT_W-1:0]        moved;
  logic                     dropWords;
  logic [MANT_W+WORD_W-1:0] extShift;
  logic                     dropBits;

  // whole-word moves; dropped words reduce into sticky
  always_comb begin
    moved     = '0;
    dropWords = 1'b0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (ctrl.moveSel[k]) begin
        moved     = mantIn >> (k * WORD_W);
        dropWords = |(mantIn & ((MANT_W'(1) << (k * WORD_W)) - MANT_W'(1)));
      end
    end
  end

  // residual shift with a spill word below the mantissa
  assign extShift = {moved, {WORD_W{1'b0}}} >> ctrl.bitSel;
  assign dropBits = |extShift[WORD_W-1:0];

  assign mantOut   = ctrl.saturate ? '0 : extShift[MANT_W+WORD_W-1:WORD_W];
  assign stickyOut = ctrl.saturate | stickyIn | dropWords | dropBits;

endmodule

// File: rtl/mant_rshift_sticky.sv
module mant_rshift_sticky
  import mrs_pkg::*;
#(
  parameter int SAT_LIMIT = 67,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] mantW0,
  input  logic [WORD_W-1:0] mantW1,
  input  logic [WORD_W-1:0] mantW2,
  input  logic              stickyIn,
  input  logic [AMT_W-1:0]  shiftAmt,
  output logic [WORD_W-1:0] mantW0Out,
  output logic [WORD_W-1:0] mantW1Out,
  output logic [WORD_W-1:0] mantW2Out,
  output logic              stickyOut
);

  shift_ctrl_t       ctrl;
  logic [MANT_W-1:0] mantCat;
  logic [MANT_W-1:0] mantNext;
  logic              stickyNext;

  assign mantCat = {mantW0, mantW1, mantW2};

  mrs_ctrl #(.SAT_LIMIT(SAT_LIMIT)) uCtrl (
    .shiftAmt(shiftAmt),
    .ctrl    (ctrl)
  );

  mrs_datapath uData (
    .mantIn   (mantCat),
    .stickyIn (stickyIn),
    .ctrl     (ctrl),
    .mantOut  (mantNext),
    .stickyOut(stickyNext)
  );

  generate
    if (REG_OUT) begin : gReg
      logic [MANT_W-1:0] mantQ;
      logic              stickyQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          mantQ   <= '0;
          stickyQ <= 1'b0;
        end else begin
          mantQ   <= mantNext;
          stickyQ <= stickyNext;
        end
      end

      assign {mantW0Out, mantW1Out, mantW2Out} = mantQ;
      assign stickyOut = stickyQ;

      // R2
      sat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        (int'(shiftAmt) >= SAT_LIMIT) |=>
          (mantW0Out == '0 && mantW1Out == '0 && mantW2Out == '0 && stickyOut));

      // R7
      sticky_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
        stickyIn |=> stickyOut);

      // R8
      zero_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
        (shiftAmt == '0) |=>
          ({mantW0Out, mantW1Out, mantW2Out} == $past(mantCat) &&
           stickyOut == $past(stickyIn)));

      // R4
      top_word_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        (int'(shiftAmt) >= WORD_W) |=> (mantW0Out == '0));

      // R3
      mid_word_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        (int'(shiftAmt) >= 2 * WORD_W) |=> (mantW1Out == '0));

      // R6
      no_new_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> ($countones({mantW0Out, mantW1Out, mantW2Out}) <=
                  $past($countones(mantCat))));
    end else begin : gComb
      assign {mantW0Out, mantW1Out, mantW2Out} = mantNext;
      assign stickyOut = stickyNext;
    end
  endgenerate

endmodule

// File: tb/mant_rshift_sticky_test.sv
`timescale 1ns/1ps
module mant_rshift_sticky_test;

  localparam int LIMIT = 67;
  localparam real HALF = 2.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] w0 = '0, w1 = '0, w2 = '0;
  logic        sIn = 1'b0;
  logic [6:0]  amt = '0;
  logic [31:0] o0, o1, o2;
  logic        sOut;

  int vecCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #(HALF) clk = ~clk;

  mant_rshift_sticky #(.SAT_LIMIT(LIMIT), .REG_OUT(1'b1)) uut (
    .clk(clk), .rstN(rstN), .mantW0(w0), .mantW1(w1), .mantW2(w2),
    .stickyIn(sIn), .shiftAmt(amt),
    .mantW0Out(o0), .mantW1Out(o1), .mantW2Out(o2), .stickyOut(sOut)
  );

  function automatic logic [95:0] refMant(logic [95:0] v, int a);
    if (a >= LIMIT) return '0;
    return v >> a;
  endfunction

  function automatic logic refSticky(logic [95:0] v, int a, logic s);
    logic [95:0] mask;
    if (a >= LIMIT) return 1'b1;
    mask = (96'(1) << a) - 96'(1);
    return s | (|(v & mask));
  endfunction

  function automatic string tagFor(int a);
    if (a >= LIMIT) return "R2";
    if (a >= 64)    return "R3";
    if (a >= 32)    return "R4";
    if (a >= 1)     return "R5";
    return "R8";
  endfunction

  task automatic compare(string tag, logic [95:0] expM, logic expS);
    vecCount++;
    if ({o0, o1, o2} !== expM || sOut !== expS) begin
      failCount++;
      $display("FAIL %s: got %h/%b expected %h/%b", tag, {o0, o1, o2}, sOut, expM, expS);
    end
  endtask

  // drive at a falling edge, check one cycle later at the next falling edge
  task automatic applyVec(logic [31:0] a0, logic [31:0] a1, logic [31:0] a2,
                          logic s, int a, string tag);
    logic [95:0] v;
    logic [95:0] prevM;
    logic        prevS;
    @(negedge clk);
    prevM = {o0, o1, o2};
    prevS = sOut;
    w0 = a0; w1 = a1; w2 = a2; sIn = s; amt = 7'(a);
    v = {a0, a1, a2};
    #1;
    // R9: nothing changes before the clock edge
    compare("R9", prevM, prevS);
    @(negedge clk);
    compare(tag, refMant(v, a), refSticky(v, a, s));
  endtask

  initial begin
    void'($urandom(32'h5EED_0A1F));
    repeat (3) @(negedge clk);
    // R9 reset state
    compare("R9", '0, 1'b0);
    rstN = 1'b1;

    // R1 word order
    applyVec(32'h0000_0001, 32'h0000_0001, 32'h0, 1'b0, 1, "R1");
    // R8 passthrough
    applyVec(32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 1'b0, 0, "R8");
    applyVec(32'h1, 32'h2, 32'h3, 1'b1, 0, "R8");
    // R2 saturation with zero mantissa
    applyVec(32'h0, 32'h0, 32'h0, 1'b0, 67, "R2");
    applyVec(32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, 127, "R2");
    applyVec(32'h8000_0000, 32'h0, 32'h0, 1'b0, 95, "R2");
    // R3 edges
    applyVec(32'h8000_0004, 32'h0, 32'h0, 1'b0, 66, "R3");
    applyVec(32'h0000_0003, 32'h0, 32'h0, 1'b0, 66, "R3");
    applyVec(32'hCAFE_F00D, 32'h0, 32'h1, 1'b0, 64, "R3");
    // R4 edges
    applyVec(32'h1234_5678, 32'h9ABC_DEF0, 32'h0, 1'b0, 32, "R4");
    applyVec(32'h1234_5678, 32'h0, 32'h0000_0001, 1'b0, 32, "R4");
    applyVec(32'hFFFF_FFFF, 32'h8000_0000, 32'h0, 1'b0, 63, "R4");
    // R5 / R6 cut-point single bits
    applyVec(32'h0, 32'h0, 32'h8000_0000, 1'b0, 31, "R6");
    applyVec(32'h0, 32'h0, 32'h8000_0000, 1'b0, 32, "R6");
    applyVec(32'h0, 32'h0, 32'h4000_0000, 1'b0, 31, "R6");
    applyVec(32'h0, 32'h0000_0001, 32'h0, 1'b0, 33, "R6");
    applyVec(32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0F0F_0F0F, 1'b0, 31, "R5");
    // R7 sticky carried
    applyVec(32'h0, 32'h0, 32'h0, 1'b1, 5, "R7");
    applyVec(32'h8000_0000, 32'h0, 32'h0, 1'b1, 40, "R7");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r0, r1, r2;
      int a;
      r0 = ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom();
      r1 = ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom();
      r2 = ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom();
      a = ($urandom_range(0, 3) == 0) ? $urandom_range(60, 70) : $urandom_range(0, 127);
      applyVec(r0, r1, r2, 1'($urandom_range(0, 1)), a, tagFor(a));
    end

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    #(HALF * 2.0 * 200000.0);
    if (!done) begin
      done = 1'b1;
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

endmodule